// File: doc/BRIEF.md
# Transport Stream PID Bitmap Filter

The block sits on two independent MPEG transport stream byte lanes and decides, packet by packet, whether each 188-byte packet is forwarded or discarded. Every lane owns a table of 1024 bytes that holds one bit for each of the 8192 possible packet identifiers (PIDs). A host programs and inspects these tables a byte at a time through three registers: a low index, a high index that also picks the table, and a data window that reads or writes the addressed byte. The host can therefore read a byte, change one bit and write it back.

On the stream side each lane takes bytes with a valid strobe and a start-of-packet flag. It pulls the PID out of header bytes 1 and 2, looks it up in its own table and applies the answer to all bytes of that packet. The output uses the same valid, start-of-packet and data signals, and each byte leaves three input bytes later, so the verdict is known before the first byte goes out. The tables are dual-ported, so host accesses never stall a lane.

Each lane runs a five-state machine. `LN_HUNT` waits for a start-of-packet byte. `LN_HDR1` holds the sync byte and waits for header byte 1. `LN_HDR2` waits for header byte 2, which starts the table lookup. `LN_RESOLVE` is the single cycle in which the table byte returns. `LN_BODY` counts the rest of the packet. Any start-of-packet byte moves the lane to `LN_HDR1` from every state. A valid byte moves `LN_HDR1` to `LN_HDR2` and `LN_HDR2` to `LN_RESOLVE`. `LN_RESOLVE` always moves to `LN_BODY` after one cycle. `LN_BODY` returns to `LN_HUNT` on a valid byte that arrives once 188 bytes have been counted.

Top module: `ts_pid_gate`

## Requirements
- R1: For a PID p, the governing bit is bit p[2:0] of table byte p[12:3]. The PID is the low 5 bits of header byte 1 (giving p[12:8]) followed by header byte 2 (giving p[7:0]). The upper 3 bits of header byte 1 are ignored.
- R2: `host_sel` 0 is the low index register, which holds index bits 7:0. `host_sel` 1 is the high index register: bits 1:0 hold index bits 9:8 and bit 2 selects the table (0 for lane 0, 1 for lane 1). When the high index register is read, bits 7:3 return zero. Reading either index register returns its current value.
- R3: A table bit of 1 drops the packet and a bit of 0 forwards it. The verdict applies to all 188 bytes of the packet, and a forwarded packet is delivered byte for byte in order, with its start flag on its first byte.
- R4: PIDs 0x00 to 0x1F are always forwarded, whatever their table bits hold.
- R5: A write with `host_sel` 2 stores `host_wdata` into the addressed table byte. A read with `host_sel` 2 presents that byte on `host_rdata` in the cycle after `host_rd`.
- R6: A packet whose first byte is not 0x47 is dropped whole.
- R7: A byte accepted at a clock edge leaves the lane on the edge that accepts the third valid byte after it. It appears with `m_valid` high for the cycle after that edge. Data and start flag are unchanged.
- R8: Bytes that belong to no packet are never output. These are bytes seen before any start flag, and bytes arriving after 188 have been counted without a new start flag. After reset no output is valid.
- R9: The lanes are independent. A table write or lookup for one lane never changes the other lane's table or traffic, and host accesses proceed while both lanes stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_sel | input | 2 | Register select: 0 index low, 1 index high, 2 table data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after `host_rd` |
| s_valid | input | 2 | Per-lane input byte valid |
| s_sop | input | 2 | Per-lane start-of-packet flag |
| s_data | input | 16 | Per-lane input byte, lane n in bits 8n+7:8n |
| m_valid | output | 2 | Per-lane output byte valid |
| m_sop | output | 2 | Per-lane output start-of-packet flag |
| m_data | output | 16 | Per-lane output byte |

## Verification
The bench aims at PIDs that share one table byte and differ in a single bit; a design that indexes by the wrong PID bits would drop the neighbour or pass the blocked one. It blocks the bits of PIDs 0x00 to 0x1F and of PID 0x20 and checks that only 0x20 is lost; an off-by-one on that boundary would lose or leak a packet. It sends bad sync bytes, stray bytes around packets and idle gaps inside packets, and probes the exact cycle the first byte leaves. A lane that decided too late would emit the head of a packet it should drop, and one that ignored the packet count would forward filler. Host table writes run while both lanes stream, so a shared or stalled table shows up as lost or corrupted bytes.

// File: rtl/ts_pid_pkg.sv
package ts_pid_pkg;
    localparam int unsigned TS_PKT_LEN     = 188;
    localparam logic [7:0]  TS_SYNC        = 8'h47;
    localparam int unsigned FREE_PID_LIMIT = 32;

    typedef enum logic [2:0] {
        LN_HUNT,
        LN_HDR1,
        LN_HDR2,
        LN_RESOLVE,
        LN_BODY
    } lane_state_e;

    typedef enum logic [1:0] {
        HS_IDX_LO = 2'd0,
        HS_IDX_HI = 2'd1,
        HS_DATA   = 2'd2,
        HS_NONE   = 2'd3
    } host_sel_e;
endpackage

// File: rtl/ts_pid_bitmap_ram.sv
module ts_pid_bitmap_ram #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = 10
) (
    input  logic          clk,
    input  logic          h_en,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    h_rdata,
    input  logic          l_en,
    input  logic [AW-1:0] l_addr,
    output logic [7:0]    l_rdata
);
    logic [7:0] mem [DEPTH];

    // host port: write plus registered read (old value on a write cycle)
    always_ff @(posedge clk) begin
        if (h_en && h_we) begin
            mem[h_addr] <= h_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (h_en) begin
            h_rdata <= mem[h_addr];
        end
    end

    // lane port: registered lookup, never blocked by the host
    always_ff @(posedge clk) begin
        if (l_en) begin
            l_rdata <= mem[l_addr];
        end
    end
endmodule

// File: rtl/ts_pid_host_regs.sv
module ts_pid_host_regs
    import ts_pid_pkg::*;
#(
    parameter int unsigned AW        = 10,
    parameter int unsigned NUM_LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic                   host_rd,
    input  logic [1:0]             host_sel,
    input  logic [7:0]             host_wdata,
    output logic [7:0]             host_rdata,
    output logic [AW-1:0]          tbl_idx,
    output logic [((NUM_LANES > 1) ? $clog2(NUM_LANES) : 1)-1:0] tbl_fsel,
    output logic                   tbl_en,
    output logic                   tbl_we,
    input  logic [NUM_LANES*8-1:0] bank_q
);
    localparam int unsigned HI_W = AW - 8;
    localparam int unsigned FS_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    logic [7:0]      idx_lo_q;
    logic [HI_W-1:0] idx_hi_q;
    logic [FS_W-1:0] fsel_q;
    host_sel_e       rsel_q;
    logic [FS_W-1:0] rfs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_lo_q <= '0;
            idx_hi_q <= '0;
            fsel_q   <= '0;
        end else if (host_wr) begin
            if (host_sel == HS_IDX_LO) begin
                idx_lo_q <= host_wdata;
            end else if (host_sel == HS_IDX_HI) begin
                idx_hi_q <= host_wdata[HI_W-1:0];
                fsel_q   <= host_wdata[HI_W +: FS_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsel_q <= HS_NONE;
            rfs_q  <= '0;
        end else if (host_rd) begin
            rsel_q <= host_sel_e'(host_sel);
            rfs_q  <= fsel_q;
        end
    end

    assign tbl_idx  = {idx_hi_q, idx_lo_q};
    assign tbl_fsel = fsel_q;
    assign tbl_en   = (host_wr || host_rd) && (host_sel == HS_DATA);
    assign tbl_we   = host_wr && (host_sel == HS_DATA);

    always_comb begin
        unique case (rsel_q)
            HS_IDX_LO: host_rdata = idx_lo_q;
            HS_IDX_HI: host_rdata = 8'({fsel_q, idx_hi_q});
            HS_DATA:   host_rdata = bank_q[rfs_q*8 +: 8];
            default:   host_rdata = 8'h00;
        endcase
    end

    a_r2_low_index_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == HS_IDX_LO) |=> (tbl_idx[7:0] == $past(host_wdata)));

    a_r2_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr) |=> $stable(tbl_idx));
endmodule

// File: rtl/ts_pid_lane.sv
module ts_pid_lane
    import ts_pid_pkg::*;
#(
    parameter int unsigned PID_W   = 13,
    parameter int unsigned PKT_LEN = TS_PKT_LEN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_valid,
    input  logic                s_sop,
    input  logic [7:0]          s_data,
    output logic                lk_en,
    output logic [PID_W-4:0]    lk_addr,
    input  logic [7:0]          lk_q,
    output logic                m_valid,
    output logic                m_sop,
    output logic [7:0]          m_data
);
    localparam int unsigned HI_W   = PID_W - 8;
    localparam int unsigned CNT_W  = $clog2(PKT_LEN + 1);
    localparam int unsigned PIPE_D = 3;

    lane_state_e state_q, state_d;

    logic [CNT_W-1:0] cnt_q;
    logic             sync_q;
    logic             small_q;
    logic             verdict_q;
    logic             pass_out_q;
    logic [HI_W-1:0]  pid_hi_q;
    logic [2:0]       bit_q;

    logic [7:0]        pd_q [PIPE_D];
    logic [PIPE_D-1:0] ps_q;
    logic [PIPE_D-1:0] pm_q;

    logic             in_member;
    logic             fresh;
    logic             pass_sel;
    logic             head_pop;
    logic             keep_pop;
    logic [PID_W-1:0] pid_now;

    assign in_member = s_sop || ((state_q != LN_HUNT) && (cnt_q < CNT_W'(PKT_LEN)));
    assign pid_now   = {pid_hi_q, s_data};
    assign lk_en     = s_valid && !s_sop && (state_q == LN_HDR2);
    assign lk_addr   = pid_now[PID_W-1:3];
    assign fresh     = sync_q && (small_q || !lk_q[bit_q]);

    // verdict used for a packet head leaving the pipeline
    always_comb begin
        unique case (state_q)
            LN_RESOLVE: pass_sel = fresh;
            LN_BODY:    pass_sel = verdict_q;
            default:    pass_sel = 1'b0;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (s_valid && s_sop) begin
            state_d = LN_HDR1;
        end else begin
            unique case (state_q)
                LN_HUNT:    state_d = LN_HUNT;
                LN_HDR1:    if (s_valid) state_d = LN_HDR2;
                LN_HDR2:    if (s_valid) state_d = LN_RESOLVE;
                LN_RESOLVE: state_d = LN_BODY;
                LN_BODY:    if (s_valid && !in_member) state_d = LN_HUNT;
                default:    state_d = LN_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LN_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // header capture and packet count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sync_q    <= 1'b0;
            small_q   <= 1'b0;
            verdict_q <= 1'b0;
            pid_hi_q  <= '0;
            bit_q     <= '0;
        end else begin
            if (s_valid) begin
                if (s_sop) begin
                    cnt_q  <= CNT_W'(1);
                    sync_q <= (s_data == TS_SYNC);
                end else if (in_member) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                if (!s_sop && state_q == LN_HDR1) begin
                    pid_hi_q <= s_data[HI_W-1:0];
                end
                if (lk_en) begin
                    bit_q   <= pid_now[2:0];
                    small_q <= (pid_now < PID_W'(FREE_PID_LIMIT));
                end
            end
            if (state_q == LN_RESOLVE) begin
                verdict_q <= fresh;
            end
        end
    end

    assign head_pop = s_valid && pm_q[PIPE_D-1] && ps_q[PIPE_D-1];
    assign keep_pop = pm_q[PIPE_D-1] && (ps_q[PIPE_D-1] ? pass_sel : pass_out_q);

    // delay line and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PIPE_D; i++) begin
                pd_q[i] <= '0;
            end
            ps_q       <= '0;
            pm_q       <= '0;
            pass_out_q <= 1'b0;
            m_valid    <= 1'b0;
            m_sop      <= 1'b0;
            m_data     <= '0;
        end else if (s_valid) begin
            for (int i = PIPE_D - 1; i > 0; i--) begin
                pd_q[i] <= pd_q[i-1];
            end
            pd_q[0]    <= s_data;
            ps_q       <= {ps_q[PIPE_D-2:0], s_sop};
            pm_q       <= {pm_q[PIPE_D-2:0], in_member};
            m_valid    <= keep_pop;
            m_sop      <= keep_pop && ps_q[PIPE_D-1];
            m_data     <= pd_q[PIPE_D-1];
            if (head_pop) begin
                pass_out_q <= pass_sel;
            end
        end else begin
            m_valid <= 1'b0;
            m_sop   <= 1'b0;
        end
    end

    a_r7_out_needs_in: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> $past(s_valid));

    a_r7_sop_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        m_sop |-> m_valid);

    a_r8_start_enters_header: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_sop) |=> (state_q == LN_HDR1));

    a_r1_resolve_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_RESOLVE) |=> (state_q != LN_RESOLVE));

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(PKT_LEN));
endmodule

// File: rtl/ts_pid_gate.sv
module ts_pid_gate
    import ts_pid_pkg::*;
#(
    parameter int unsigned NUM_LANES = 2,
    parameter int unsigned PID_W     = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic                   host_rd,
    input  logic [1:0]             host_sel,
    input  logic [7:0]             host_wdata,
    output logic [7:0]             host_rdata,
    input  logic [NUM_LANES-1:0]   s_valid,
    input  logic [NUM_LANES-1:0]   s_sop,
    input  logic [NUM_LANES*8-1:0] s_data,
    output logic [NUM_LANES-1:0]   m_valid,
    output logic [NUM_LANES-1:0]   m_sop,
    output logic [NUM_LANES*8-1:0] m_data
);
    localparam int unsigned AW    = PID_W - 3;
    localparam int unsigned DEPTH = 1 << AW;
    localparam int unsigned FS_W  = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

    logic [AW-1:0]          tbl_idx;
    logic [FS_W-1:0]        tbl_fsel;
    logic                   tbl_en;
    logic                   tbl_we;
    logic [NUM_LANES*8-1:0] bank_q;

    ts_pid_host_regs #(
        .AW        (AW),
        .NUM_LANES (NUM_LANES)
    ) host_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .tbl_idx    (tbl_idx),
        .tbl_fsel   (tbl_fsel),
        .tbl_en     (tbl_en),
        .tbl_we     (tbl_we),
        .bank_q     (bank_q)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic          lk_en;
        logic [AW-1:0] lk_addr;
        logic [7:0]    lk_q;
        logic          bank_hit;

        assign bank_hit = tbl_en && (tbl_fsel == FS_W'(g));

        ts_pid_bitmap_ram #(
            .DEPTH (DEPTH),
            .AW    (AW)
        ) ram_i (
            .clk     (clk),
            .h_en    (bank_hit),
            .h_we    (tbl_we),
            .h_addr  (tbl_idx),
            .h_wdata (host_wdata),
            .h_rdata (bank_q[g*8 +: 8]),
            .l_en    (lk_en),
            .l_addr  (lk_addr),
            .l_rdata (lk_q)
        );

        ts_pid_lane #(
            .PID_W (PID_W)
        ) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .s_valid (s_valid[g]),
            .s_sop   (s_sop[g]),
            .s_data  (s_data[g*8 +: 8]),
            .lk_en   (lk_en),
            .lk_addr (lk_addr),
            .lk_q    (lk_q),
            .m_valid (m_valid[g]),
            .m_sop   (m_sop[g]),
            .m_data  (m_data[g*8 +: 8])
        );
    end
endmodule

// File: tb/ts_pid_gate_tb_top.sv
module ts_pid_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic [1:0]  m_valid, m_sop;
    logic [15:0] m_data;

    logic        lv0 = 1'b0, lv1 = 1'b0, ls0 = 1'b0, ls1 = 1'b0;
    logic [7:0]  ld0 = 8'd0, ld1 = 8'd0;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [8:0] expq0 [$];
    logic [8:0] expq1 [$];
    logic [7:0] tbl [2][1024];

    always #4 clk = ~clk;

    ts_pid_gate dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .s_valid    ({lv1, lv0}),
        .s_sop      ({ls1, ls0}),
        .s_data     ({ld1, ld0}),
        .m_valid    (m_valid),
        .m_sop      (m_sop),
        .m_data     (m_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int l = 0; l < 2; l++) begin
                if (m_valid[l]) begin
                    logic [8:0] got;
                    got = {m_sop[l], m_data[l*8 +: 8]};
                    if ((l == 0 && expq0.size() == 0) || (l == 1 && expq1.size() == 0)) begin
                        check("R8 unexpected output byte", {23'd0, got}, 32'h1ff);
                    end else if (l == 0) begin
                        check("R3 lane0 byte", {23'd0, got}, {23'd0, expq0.pop_front()});
                    end else begin
                        check("R3 lane1 byte", {23'd0, got}, {23'd0, expq1.pop_front()});
                    end
                end
            end
        end
    end

    task automatic drive(input int l, input logic v, input logic sop, input logic [7:0] d);
        if (l == 0) begin lv0 = v; ls0 = sop; ld0 = d; end
        else        begin lv1 = v; ls1 = sop; ld1 = d; end
    endtask

    task automatic send_byte(input int l, input logic [7:0] d, input logic sop, input logic keep);
        @(negedge clk);
        drive(l, 1'b1, sop, d);
        if (keep) begin
            if (l == 0) expq0.push_back({sop, d});
            else        expq1.push_back({sop, d});
        end
    endtask

    task automatic idle(input int l);
        @(negedge clk);
        drive(l, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic send_packet(input int l, input logic [12:0] pid, input logic [7:0] sync,
                               input bit gaps, input bit probe);
        bit pass;
        pass = (sync == 8'h47) && ((pid < 13'h20) || !tbl[l][pid[12:3]][pid[2:0]]);
        for (int i = 0; i < 188; i++) begin
            logic [7:0] b;
            if (i == 0)      b = sync;
            else if (i == 1) b = {3'b010, pid[12:8]};
            else if (i == 2) b = pid[7:0];
            else             b = 8'(i * 7 + pid);
            send_byte(l, b, i == 0, pass);
            if (probe && i == 3) check("R7 head not out before 3rd later byte", {31'd0, m_valid[l]}, 32'd0);
            if (probe && i == 4) check("R7 head leaves after 3rd later byte",
                                       {22'd0, m_valid[l], m_sop[l], m_data[l*8 +: 8]}, {22'd0, 2'b11, 8'h47});
            if (gaps && (i % 5 == 2)) idle(l);
        end
        idle(l);
    endtask

    task automatic flush(input int l);
        for (int i = 0; i < 3; i++) send_byte(l, 8'hE0 + 8'(i), 1'b0, 1'b0);
        idle(l);
    endtask

    task automatic hwrite(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_sel = sel;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic set_byte(input int f, input logic [9:0] idx, input logic [7:0] v);
        hwrite(2'd0, idx[7:0]);
        hwrite(2'd1, {5'd0, 1'(f), idx[9:8]});
        hwrite(2'd2, v);
        tbl[f][idx] = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 no output after reset", {30'd0, m_valid}, 32'd0);

        // R2 index registers
        hread(2'd0, rd);
        check("R2 low index reset", {24'd0, rd}, 32'd0);
        hwrite(2'd0, 8'hA5);
        hwrite(2'd1, 8'hFF);
        hread(2'd0, rd);
        check("R2 low index readback", {24'd0, rd}, 32'hA5);
        hread(2'd1, rd);
        check("R2 high index keeps bits 2:0", {24'd0, rd}, 32'h07);

        // clear both tables
        for (int f = 0; f < 2; f++)
            for (int i = 0; i < 1024; i++)
                set_byte(f, 10'(i), 8'h00);

        // R5 readback and R9 table separation
        set_byte(1, 10'h2C3, 8'h5A);
        hread(2'd2, rd);
        check("R5 table byte readback", {24'd0, rd}, 32'h5A);
        hwrite(2'd1, 8'h02);
        hread(2'd2, rd);
        check("R9 other table untouched", {24'd0, rd}, 32'h00);
        set_byte(1, 10'h2C3, 8'h00);

        // R7 exact latency on lane 0
        send_packet(0, 13'h100, 8'h47, 1'b0, 1'b1);
        flush(0);

        // R3 / R1 neighbour bits, R9 other lane unaffected
        set_byte(0, 10'h2A, 8'h20);
        send_packet(0, 13'h155, 8'h47, 1'b0, 1'b0); flush(0);
        send_packet(0, 13'h154, 8'h47, 1'b1, 1'b0); flush(0);
        send_packet(1, 13'h155, 8'h47, 1'b0, 1'b0); flush(1);

        // R4 low PID band
        for (int i = 0; i < 4; i++) set_byte(0, 10'(i), 8'hFF);
        set_byte(0, 10'h4, 8'h01);
        send_packet(0, 13'h1F, 8'h47, 1'b0, 1'b0); flush(0);
        send_packet(0, 13'h00, 8'h47, 1'b0, 1'b0); flush(0);
        send_packet(0, 13'h20, 8'h47, 1'b0, 1'b0); flush(0);
        send_packet(0, 13'h21, 8'h47, 1'b0, 1'b0); flush(0);

        // R1 top PID by read-modify-write on table 1
        hwrite(2'd0, 8'hFF);
        hwrite(2'd1, 8'h07);
        hread(2'd2, rd);
        check("R5 top byte before update", {24'd0, rd}, 32'h00);
        hwrite(2'd2, rd | 8'h80);
        tbl[1][1023] = rd | 8'h80;
        send_packet(1, 13'h1FFF, 8'h47, 1'b0, 1'b0); flush(1);
        send_packet(1, 13'h1FFE, 8'h47, 1'b1, 1'b0); flush(1);

        // R6 bad sync, then a good packet back to back
        send_packet(0, 13'h100, 8'h48, 1'b0, 1'b0);
        send_packet(0, 13'h101, 8'h47, 1'b0, 1'b0); flush(0);

        // R8 stray bytes ahead of a packet
        for (int i = 0; i < 5; i++) send_byte(1, 8'h47, 1'b0, 1'b0);
        send_packet(1, 13'h100, 8'h47, 1'b1, 1'b0); flush(1);

        // R9 both lanes streaming while host writes
        fork
            begin send_packet(0, 13'h154, 8'h47, 1'b1, 1'b0); flush(0); end
            begin send_packet(1, 13'h1FFF, 8'h47, 1'b0, 1'b0);
                  send_packet(1, 13'h0300, 8'h47, 1'b0, 1'b0); flush(1); end
            begin set_byte(0, 10'h200, 8'hFF); set_byte(1, 10'h3FE, 8'h00); end
        join

        repeat (8) @(negedge clk);
        check("R3 lane0 all expected bytes delivered", expq0.size(), 32'd0);
        check("R3 lane1 all expected bytes delivered", expq1.size(), 32'd0);
        finish_run();
    end
endmodule